// File: doc/BRIEF.md
# DRAM Rank-Select Command Issuer

This block turns single read requests, each carrying a flat byte-free word address, into the command sequence a DDR-style memory channel expects. It splits the address into column, bank, row and rank fields. It drives one active-low chip select for the addressed rank. It issues a bank-activate followed by a read, then captures the returned read word in a configured cycle and hands it back on a response stream.

A 1T/2T command-rate input controls the first command of a random access. Under 2T the bank, row and decoded rank are set up one cycle ahead while every chip select stays high, and only then is the activate issued. A registered-module input forces 2T timing and moves the read-capture cycle one clock later, because the module's buffer delays address and command by one edge. The block keeps the last activated rank/bank/row as open. A request that hits that row skips the activate and its decode cycle and goes straight to the read. A rank mask input folds the rank field onto the populated ranks; with a mask of zero, every access goes to rank 0 without decoding.

Both data-carrying interfaces use valid/ready. A request transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only when no access is in flight and no response is waiting. A response is offered with `rsp_valid` and is held, with `rsp_data` unchanged, until `rsp_ready` is seen high at a clock edge. Configuration inputs are expected to stay static while an access is in flight.

Top module: `rank_cmd_issuer`

## Requirements
- R1: After reset, `in_ready` is 1, `rsp_valid` is 0, `cap_strobe` is 0, all `cmd_cs_n` bits are 1 and the command pins encode NOP.
- R2: The rank is the two address bits directly above the row field (bits [23:22] with default widths). Row is [21:10], bank is [9:8] and column is [7:0]. During an activate or read exactly one `cmd_cs_n` bit is low: bit number equal to the rank.
- R3: The effective rank is the rank field ANDed with `cfg_rank_mask`; with mask 0 every access selects rank 0.
- R4: Commands are encoded on {ras_n,cas_n,we_n} as NOP=111, ACTIVATE=011, READ=101. In every cycle with NOP all `cmd_cs_n` bits are 1.
- R5: With 1T rate and unregistered mode, a row miss issues ACTIVATE (with `cmd_addr`=row, `cmd_ba`=bank) in the first cycle after the accepting edge.
- R6: With 2T rate, a row miss issues ACTIVATE in the second cycle after the accepting edge. The cycle before it carries NOP with all chip selects high and `cmd_addr`/`cmd_ba` already showing row and bank.
- R7: READ is issued exactly `cfg_trcd` cycles after ACTIVATE (`cfg_trcd` >= 1), with `cmd_addr` holding the zero-extended column.
- R8: `cap_strobe` is high exactly `cfg_cl` cycles after READ (`cfg_cl` >= 1) in unregistered mode and `cfg_cl`+1 cycles after it in registered mode. `dram_rdata` in that cycle becomes `rsp_data`, offered on `rsp_valid` in the following cycle.
- R9: Registered mode (`cfg_regd`=1) applies 2T activate timing even when `cfg_cmd_2t` is 0.
- R10: A request whose rank, bank and row equal the last activated ones issues no ACTIVATE. Its READ comes in the first cycle after the accepting edge, in either command rate.
- R11: A request that differs from the open row in rank, bank or row issues a fresh ACTIVATE and becomes the new open row.
- R12: While a response is unaccepted, `rsp_valid` stays 1, `rsp_data` is stable, `in_ready` is 0, and a request held on `in_valid` issues no command. `in_ready` returns to 1 the cycle after the response transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cmd_2t | input | 1 | 1 selects 2T command rate |
| cfg_regd | input | 1 | 1 selects registered-module timing |
| cfg_rank_mask | input | 2 | Mask applied to the rank field |
| cfg_trcd | input | 4 | Activate-to-read delay in cycles |
| cfg_cl | input | 4 | Read-to-data latency in cycles |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request ready |
| in_addr | input | 24 | Flat request address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_data | output | 32 | Captured read word |
| cmd_cs_n | output | 4 | Per-rank chip selects, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank address |
| cmd_addr | output | 12 | Row or column address |
| dram_rdata | input | 32 | Read word from the memory |
| cap_strobe | output | 1 | High in the read-capture cycle |

## Verification
The hardest situation to reach is a row hit under 2T or registered timing. It only exists after a previous access has left exactly that rank, bank and row open. The bench therefore chains its scenarios: a miss opens a row, and the next request reuses that row with a new column or after the rate has changed. It then changes one of rank, bank or row at a time, including a rank change made only through the mask, to force misses. The held response case is reached by keeping `rsp_ready` low while a second request waits on `in_valid`.

// File: rtl/rci_pkg.sv
package rci_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_ACT, S_GAP, S_RD, S_DATA, S_RSP
  } seq_st_t;
endpackage

// File: rtl/rci_rank_decode.sv
module rci_rank_decode #(
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int BANK_W    = 2,
  parameter int RANK_BITS = 2,
  localparam int ADDR_W   = ROW_W + COL_W + BANK_W + RANK_BITS
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [RANK_BITS-1:0] mask,
  output logic [RANK_BITS-1:0] rank,
  output logic [BANK_W-1:0]    bank,
  output logic [ROW_W-1:0]     row,
  output logic [COL_W-1:0]     col
);
  localparam int BANK_LSB = COL_W;
  localparam int ROW_LSB  = COL_W + BANK_W;
  localparam int RANK_LSB = COL_W + BANK_W + ROW_W;

  always_comb begin
    col  = addr[COL_W-1:0];
    bank = addr[BANK_LSB +: BANK_W];
    row  = addr[ROW_LSB +: ROW_W];
    rank = addr[RANK_LSB +: RANK_BITS] & mask;
  end
endmodule

// File: rtl/rci_row_tracker.sv
module rci_row_tracker #(
  parameter int ROW_W     = 12,
  parameter int BANK_W    = 2,
  parameter int RANK_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 open_en,
  input  logic [RANK_BITS-1:0] open_rank,
  input  logic [BANK_W-1:0]    open_bank,
  input  logic [ROW_W-1:0]     open_row,
  input  logic [RANK_BITS-1:0] look_rank,
  input  logic [BANK_W-1:0]    look_bank,
  input  logic [ROW_W-1:0]     look_row,
  output logic                 hit
);
  logic                 vld_q;
  logic [RANK_BITS-1:0] rank_q;
  logic [BANK_W-1:0]    bank_q;
  logic [ROW_W-1:0]     row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      rank_q <= '0;
      bank_q <= '0;
      row_q  <= '0;
    end else if (open_en) begin
      vld_q  <= 1'b1;
      rank_q <= open_rank;
      bank_q <= open_bank;
      row_q  <= open_row;
    end
  end

  assign hit = vld_q && (rank_q == look_rank) && (bank_q == look_bank)
               && (row_q == look_row);

  assert_open_recorded_R11: assert property (@(posedge clk) disable iff (!rst_n)
    open_en |=> (vld_q && rank_q == $past(open_rank) && row_q == $past(open_row)
                 && bank_q == $past(open_bank)));
endmodule

// File: rtl/rci_cmd_seq.sv
module rci_cmd_seq
  import rci_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hit,
  input  logic             use_2t,
  input  logic             regd,
  input  logic [LAT_W-1:0] cfg_trcd,
  input  logic [LAT_W-1:0] cfg_cl,
  input  logic             rsp_ready,
  output seq_st_t          st,
  output logic             in_ready,
  output logic             rsp_valid,
  output logic             strobe
);
  localparam int CNT_W = LAT_W + 1;

  seq_st_t    st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start) st_q <= hit ? S_RD : (use_2t ? S_SETUP : S_ACT);
        S_SETUP: st_q <= S_ACT;
        S_ACT: begin
          cnt_q <= {1'b0, cfg_trcd} - CNT_W'(1);
          st_q  <= (cfg_trcd <= LAT_W'(1)) ? S_RD : S_GAP;
        end
        S_GAP: begin
          if (cnt_q <= CNT_W'(1)) st_q <= S_RD;
          else cnt_q <= cnt_q - CNT_W'(1);
        end
        S_RD: begin
          cnt_q <= {1'b0, cfg_cl} + CNT_W'(regd);
          st_q  <= S_DATA;
        end
        S_DATA: begin
          if (cnt_q <= CNT_W'(1)) st_q <= S_RSP;
          else cnt_q <= cnt_q - CNT_W'(1);
        end
        S_RSP: if (rsp_ready) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign st        = st_q;
  assign in_ready  = (st_q == S_IDLE);
  assign rsp_valid = (st_q == S_RSP);
  assign strobe    = (st_q == S_DATA) && (cnt_q <= CNT_W'(1));

  assert_act_after_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ACT && use_2t) |-> ($past(st_q) == S_SETUP));
  assert_act_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ACT && !use_2t) |-> ($past(st_q) == S_IDLE));
  assert_hit_skips_act_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && hit) |=> (st_q == S_RD));
  assert_strobe_then_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (st_q == S_RSP));
  assert_trcd_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ACT) |-> (cfg_trcd != '0 && cfg_cl != '0));
endmodule

// File: rtl/rank_cmd_issuer.sv
module rank_cmd_issuer
  import rci_pkg::*;
#(
  parameter int ROW_W      = 12,
  parameter int COL_W      = 8,
  parameter int BANK_W     = 2,
  parameter int NUM_RANKS  = 4,
  parameter int LAT_W      = 4,
  parameter int DATA_W     = 32,
  localparam int RANK_BITS = $clog2(NUM_RANKS),
  localparam int ADDR_W    = ROW_W + COL_W + BANK_W + RANK_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_cmd_2t,
  input  logic                 cfg_regd,
  input  logic [RANK_BITS-1:0] cfg_rank_mask,
  input  logic [LAT_W-1:0]     cfg_trcd,
  input  logic [LAT_W-1:0]     cfg_cl,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ADDR_W-1:0]    in_addr,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_data,
  output logic [NUM_RANKS-1:0] cmd_cs_n,
  output logic                 cmd_ras_n,
  output logic                 cmd_cas_n,
  output logic                 cmd_we_n,
  output logic [BANK_W-1:0]    cmd_ba,
  output logic [ROW_W-1:0]     cmd_addr,
  input  logic [DATA_W-1:0]    dram_rdata,
  output logic                 cap_strobe
);
  logic [RANK_BITS-1:0] d_rank, rank_q, mask_q;
  logic [BANK_W-1:0]    d_bank, bank_q;
  logic [ROW_W-1:0]     d_row, row_q;
  logic [COL_W-1:0]     d_col, col_q;
  logic                 accept, hit, use_2t, strobe, cmd_live;
  seq_st_t              st;

  assign use_2t = cfg_cmd_2t | cfg_regd;
  assign accept = in_valid & in_ready;

  rci_rank_decode #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W),
                    .RANK_BITS(RANK_BITS)) u_dec (
    .addr(in_addr), .mask(cfg_rank_mask),
    .rank(d_rank), .bank(d_bank), .row(d_row), .col(d_col));

  rci_row_tracker #(.ROW_W(ROW_W), .BANK_W(BANK_W), .RANK_BITS(RANK_BITS)) u_trk (
    .clk(clk), .rst_n(rst_n), .open_en(st == S_ACT),
    .open_rank(rank_q), .open_bank(bank_q), .open_row(row_q),
    .look_rank(d_rank), .look_bank(d_bank), .look_row(d_row), .hit(hit));

  rci_cmd_seq #(.LAT_W(LAT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .hit(hit), .use_2t(use_2t),
    .regd(cfg_regd), .cfg_trcd(cfg_trcd), .cfg_cl(cfg_cl), .rsp_ready(rsp_ready),
    .st(st), .in_ready(in_ready), .rsp_valid(rsp_valid), .strobe(strobe));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rank_q <= '0;
      mask_q <= '0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else if (accept) begin
      rank_q <= d_rank;
      mask_q <= cfg_rank_mask;
      bank_q <= d_bank;
      row_q  <= d_row;
      col_q  <= d_col;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_data <= '0;
    else if (strobe) rsp_data <= dram_rdata;
  end

  assign cap_strobe = strobe;
  assign cmd_live   = (st == S_ACT) || (st == S_RD);

  for (genvar i = 0; i < NUM_RANKS; i++) begin : g_cs
    assign cmd_cs_n[i] = !(cmd_live && (rank_q == RANK_BITS'(i)));
  end

  always_comb begin
    cmd_ras_n = 1'b1;
    cmd_cas_n = 1'b1;
    cmd_we_n  = 1'b1;
    cmd_ba    = '0;
    cmd_addr  = '0;
    unique case (st)
      S_SETUP: begin
        cmd_ba   = bank_q;
        cmd_addr = row_q;
      end
      S_ACT: begin
        cmd_ras_n = 1'b0;
        cmd_ba    = bank_q;
        cmd_addr  = row_q;
      end
      S_RD: begin
        cmd_cas_n = 1'b0;
        cmd_ba    = bank_q;
        cmd_addr  = ROW_W'(col_q);
      end
      default: ;
    endcase
  end

  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cmd_cs_n) && (cmd_live -> ($countones(~cmd_cs_n) == 1)));
  assert_nop_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ras_n && cmd_cas_n && cmd_we_n) |-> (&cmd_cs_n));
  assert_rank_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_live |-> ((rank_q & ~mask_q) == '0));
  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && !in_ready));
endmodule

// File: tb/sim_rank_cmd_issuer.sv
`timescale 1ns/1ps
module sim_rank_cmd_issuer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_cmd_2t = 1'b0, cfg_regd = 1'b0;
  logic [1:0]  cfg_rank_mask = 2'b11;
  logic [3:0]  cfg_trcd = 4'd3, cfg_cl = 4'd2;
  logic        in_valid = 1'b0, rsp_ready = 1'b1;
  logic [23:0] in_addr = '0;
  logic        in_ready, rsp_valid, cmd_ras_n, cmd_cas_n, cmd_we_n, cap_strobe;
  logic [31:0] rsp_data, dram_rdata;
  logic [3:0]  cmd_cs_n;
  logic [1:0]  cmd_ba;
  logic [11:0] cmd_addr;

  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  rank_cmd_issuer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_cmd_2t(cfg_cmd_2t), .cfg_regd(cfg_regd),
    .cfg_rank_mask(cfg_rank_mask), .cfg_trcd(cfg_trcd), .cfg_cl(cfg_cl),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
    .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr),
    .dram_rdata(dram_rdata), .cap_strobe(cap_strobe));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fdat(input logic [3:0] csn, input logic [7:0] col);
    return {8'hD0, 4'h0, csn, 8'h5A, col};
  endfunction

  // memory model and command monitor
  int n_act = 0, act_cyc = -1, rd_cyc = -1, stb_cyc = -1, data_cyc = -1;
  logic [3:0]  act_cs, rd_cs, pre_cs, prv_cs = 4'hF;
  logic [11:0] act_addr, rd_addr, pre_addr, prv_addr = '0;
  logic [1:0]  act_ba, rd_ba, pre_ba, prv_ba = '0;
  logic        pre_nop, prv_nop = 1'b1, cmd_bad = 1'b0;
  logic [31:0] data_val = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    logic is_nop, is_act, is_rd;
    is_nop = cmd_ras_n && cmd_cas_n && cmd_we_n;
    is_act = !cmd_ras_n && cmd_cas_n && cmd_we_n;
    is_rd  = cmd_ras_n && !cmd_cas_n && cmd_we_n;
    if (rst_n) begin
      if (is_nop && cmd_cs_n != 4'hF) cmd_bad = 1'b1;
      if (!is_nop && $countones(~cmd_cs_n) != 1) cmd_bad = 1'b1;
      if (!is_nop && !is_act && !is_rd) cmd_bad = 1'b1;
      if (is_act) begin
        n_act++; act_cyc = cyc; act_cs = cmd_cs_n; act_addr = cmd_addr; act_ba = cmd_ba;
        pre_cs = prv_cs; pre_addr = prv_addr; pre_ba = prv_ba; pre_nop = prv_nop;
      end
      if (is_rd) begin
        rd_cyc = cyc; rd_cs = cmd_cs_n; rd_addr = cmd_addr; rd_ba = cmd_ba;
        data_cyc = cyc + int'(cfg_cl) + (cfg_regd ? 1 : 0);
        data_val = fdat(cmd_cs_n, cmd_addr[7:0]);
      end
      if (cap_strobe) stb_cyc = cyc;
    end
    dram_rdata = (cyc == data_cyc) ? data_val : 32'hBAD0_BAD0;
    prv_cs = cmd_cs_n; prv_addr = cmd_addr; prv_ba = cmd_ba; prv_nop = is_nop;
  end

  // one access; hold = cycles the response is refused
  task automatic access(input logic [1:0] rank_raw, input logic [11:0] row,
                        input logic [1:0] bank, input logic [7:0] col,
                        input bit exp_hit, input int hold, input string tag);
    int acc, extra, lat, exp_act, exp_rd, waited;
    logic [1:0] rank;
    logic [3:0] exp_cs;
    logic [31:0] held;
    rank   = rank_raw & cfg_rank_mask;
    exp_cs = ~(4'b0001 << rank);
    extra  = (cfg_cmd_2t || cfg_regd) ? 1 : 0;
    lat    = int'(cfg_cl) + (cfg_regd ? 1 : 0);
    @(negedge clk);
    n_act = 0; act_cyc = -1; rd_cyc = -1; stb_cyc = -1; cmd_bad = 1'b0;
    rsp_ready = (hold == 0);
    in_addr  = {rank_raw, row, bank, col};
    in_valid = 1'b1;
    waited = 0;
    while (!in_ready && waited < 100) begin @(negedge clk); waited++; end
    acc = cyc;
    @(negedge clk);
    in_valid = 1'b0;
    waited = 0;
    while (!rsp_valid && waited < 100) begin @(negedge clk); waited++; end
    chk(rsp_valid, {tag, " R8 response arrives"}, rsp_valid, 1);
    if (hold > 0) begin
      held = rsp_data;
      for (int i = 0; i < hold; i++) begin
        in_valid = 1'b1;
        in_addr  = {2'd0, 12'hFFF, 2'd3, 8'hFF};
        @(negedge clk);
        chk(rsp_valid && rsp_data == held, {tag, " R12 response held"}, rsp_data, held);
        chk(!in_ready, {tag, " R12 not ready while held"}, in_ready, 0);
      end
      in_valid = 1'b0;
      chk(n_act == (exp_hit ? 0 : 1) && rd_cyc >= 0 && rd_cyc < acc + 20,
          {tag, " R12 waiting request issues nothing"}, n_act, exp_hit ? 0 : 1);
      rsp_ready = 1'b1;
      @(negedge clk);
      chk(!rsp_valid && in_ready, {tag, " R12 ready after transfer"}, {rsp_valid, in_ready}, 2'b01);
    end
    if (exp_hit) begin
      chk(n_act == 0, {tag, " R10 no activate on hit"}, n_act, 0);
      exp_rd = acc + 1;
    end else begin
      exp_act = acc + 1 + extra;
      chk(n_act == 1, {tag, " R11 one activate on miss"}, n_act, 1);
      chk(act_cyc == exp_act, {tag, extra ? " R6 R9 activate cycle" : " R5 activate cycle"},
          act_cyc - acc, exp_act - acc);
      chk(act_cs == exp_cs && act_addr == row && act_ba == bank,
          {tag, " R2 R3 activate rank/row/bank"}, {act_cs, act_addr, act_ba}, {exp_cs, row, bank});
      if (extra == 1)
        chk(pre_nop && pre_cs == 4'hF && pre_addr == row && pre_ba == bank,
            {tag, " R6 setup cycle"}, {pre_nop, pre_cs, pre_addr}, {1'b1, 4'hF, row});
      exp_rd = exp_act + int'(cfg_trcd);
    end
    chk(rd_cyc == exp_rd, {tag, " R7 R10 read cycle"}, rd_cyc - acc, exp_rd - acc);
    chk(rd_cs == exp_cs && rd_addr == {4'h0, col} && rd_ba == bank,
        {tag, " R7 read column"}, {rd_cs, rd_addr}, {exp_cs, 4'h0, col});
    chk(stb_cyc == exp_rd + lat, {tag, " R8 capture cycle"}, stb_cyc - acc, exp_rd + lat - acc);
    chk(rsp_data == fdat(exp_cs, col), {tag, " R8 captured data"}, rsp_data, fdat(exp_cs, col));
    chk(!cmd_bad, {tag, " R4 command encoding"}, cmd_bad, 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready && !rsp_valid && !cap_strobe, "R1 handshake reset", {in_ready, rsp_valid, cap_strobe}, 3'b100);
    chk(cmd_cs_n == 4'hF && cmd_ras_n && cmd_cas_n && cmd_we_n, "R1 R4 nop at reset",
        {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}, 7'h7F);
  endtask

  task automatic t_rate_1t();
    cfg_cmd_2t = 0; cfg_regd = 0; cfg_trcd = 3; cfg_cl = 2;
    access(2'd2, 12'h123, 2'd1, 8'h45, 0, 0, "1t-miss");
    access(2'd2, 12'h123, 2'd1, 8'h10, 1, 0, "1t-hit");
  endtask

  task automatic t_rate_2t();
    cfg_cmd_2t = 1; cfg_trcd = 2; cfg_cl = 3;
    access(2'd2, 12'h124, 2'd1, 8'h33, 0, 0, "2t-miss");
    access(2'd2, 12'h124, 2'd1, 8'h77, 1, 0, "2t-hit");
    access(2'd2, 12'h124, 2'd2, 8'h01, 0, 0, "2t-bank-change");
  endtask

  task automatic t_registered();
    cfg_cmd_2t = 0; cfg_regd = 1; cfg_trcd = 1; cfg_cl = 3;
    access(2'd3, 12'h0AB, 2'd0, 8'hC3, 0, 0, "regd-miss");
    access(2'd3, 12'h0AB, 2'd0, 8'h3C, 1, 0, "regd-hit");
  endtask

  task automatic t_mask();
    cfg_regd = 0; cfg_cmd_2t = 0; cfg_trcd = 2; cfg_cl = 1;
    cfg_rank_mask = 2'b01;
    access(2'd3, 12'h0AB, 2'd0, 8'h11, 0, 0, "mask01-rank1");
    cfg_rank_mask = 2'b00;
    access(2'd3, 12'h0AB, 2'd0, 8'h22, 0, 0, "mask00-rank0");
    access(2'd1, 12'h0AB, 2'd0, 8'h23, 1, 0, "mask00-fold-hit");
    cfg_rank_mask = 2'b11;
  endtask

  task automatic t_backpressure();
    cfg_trcd = 2; cfg_cl = 2;
    access(2'd1, 12'h555, 2'd3, 8'h99, 0, 4, "bp-miss");
    access(2'd1, 12'h555, 2'd3, 8'h98, 1, 3, "bp-hit");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rate_1t();
    t_rate_2t();
    t_registered();
    t_mask();
    t_backpressure();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule